// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM controller must spend cycles on auto-refresh commands so that every row is refreshed before its charge decays. It counts system clocks from a per-row interval derived from the clock rate, the retention window and the row count. It issues requests to the controller's command arbiter through a request/grant handshake. The device advances its own internal row pointer on each auto-refresh, so the scheduler only counts commands and never drives a row address.

Two schedules are selectable. In spread mode one refresh is requested per row interval. In clustered mode a burst of `BURST_N` refreshes is issued as one event, once per `BURST_N` row intervals, with a programmable recovery gap between successive commands of the burst. Both interval lengths are rounded down, so the deadline is never overrun. A schedule built for a short window is also valid for a device with a longer window, because refreshing early never harms retention. Intervals that expire while the arbiter is slow are held in a small owed-event counter. A sticky warning flag rises once that counter reaches its limit.

The state machine has four states. `S_WAIT_INIT` is entered at reset and holds everything quiet. It moves to `S_IDLE` when `init_done` is sampled high. `S_IDLE` moves to `S_REQ` when at least one event is owed. `S_REQ` raises the request. On a grant it either returns to `S_IDLE`, when this was the last command of the event, or moves to `S_GAP`. `S_GAP` waits out the recovery time and then returns to `S_REQ`.

Top module: `refresh_sched`

## Requirements
- R1: After reset `ref_req`, `ref_busy` and `ref_late` are 0, and no request is raised while `init_done` has not been sampled high.
- R2: With `grouped_mode`=0 and grants given at once, the first request is visible RI+2 clocks after the edge that samples `init_done` high (counting that edge as 1). Each later request rises RI clocks after the previous one, where RI = floor(CLK_MHZ*WINDOW_US/ROWS).
- R3: With `grouped_mode`=1 the same timing applies with GI = floor(CLK_MHZ*WINDOW_US*BURST_N/ROWS) in place of RI. GI is rounded down on its own, not computed as BURST_N*RI.
- R4: An event in clustered mode receives exactly BURST_N grants, and a spread-mode event receives exactly 1. Between a grant and the next request of the same event, `ref_req` is low for max(`trfc_clks`,1) clocks.
- R5: `ref_busy` is high from the first request of an event through its last grant, including every recovery gap. It drops the clock after the last grant when no further event is owed.
- R6: Once raised, `ref_req` stays high until a clock in which `ref_gnt` is high.
- R7: Intervals that expire while a request waits are counted, up to PEND_LIMIT, and served later one after another, so none is lost.
- R8: `ref_late` rises one clock after the owed count reaches PEND_LIMIT and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Device initialisation complete; starts the interval timer |
| grouped_mode | input | 1 | 0 = one refresh per row interval, 1 = bursts of BURST_N |
| trfc_clks | input | TRFC_W | Recovery clocks between commands of one burst |
| ref_gnt | input | 1 | Arbiter accepts the pending refresh command this clock |
| ref_req | output | 1 | Refresh command wanted |
| ref_busy | output | 1 | A refresh event is in progress |
| ref_late | output | 1 | Sticky: owed events reached PEND_LIMIT |

## Verification
The bench measures the exact latency from `init_done` to the first request and the spacing of later events in both modes. It uses a window that does not divide evenly, so an implementation that forms the burst interval as BURST_N times the rounded row interval arrives three clocks early. It sweeps the recovery count through zero, a mid value and a larger value. A zero count that stalls or skips the gap, or a gap state that drops `ref_busy`, shows up as a wrong gap length or a wrong command count. It withholds grants across several intervals to check that owed events are all served afterwards, and that the late flag rises exactly at the limit and stays high. A counter that forgets a tick or a flag that clears itself would fail these checks.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        S_WAIT_INIT = 2'd0,
        S_IDLE      = 2'd1,
        S_REQ       = 2'd2,
        S_GAP       = 2'd3
    } rs_state_e;

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int unsigned ROW_IVL = 8,
    parameter int unsigned GRP_IVL = 32,
    parameter int unsigned CNT_W   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic grouped,
    output logic tick
);
    localparam logic [CNT_W-1:0] ROW_RL = CNT_W'(ROW_IVL - 1);
    localparam logic [CNT_W-1:0] GRP_RL = CNT_W'(GRP_IVL - 1);

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;

    assign reload = grouped ? GRP_RL : ROW_RL;
    assign tick   = running && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (!running) begin
            if (start) begin
                running <= 1'b1;
                cnt     <= reload;
            end
        end else if (cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_NO_TICK_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> !tick); // R1

endmodule

// File: rtl/refsched_pending.sv
module refsched_pending #(
    parameter int unsigned LIMIT  = 4,
    parameter int unsigned PEND_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic owed,
    output logic late
);
    localparam logic [PEND_W-1:0] LIM = PEND_W'(LIMIT);

    logic [PEND_W-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            late <= 1'b0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (pend < LIM) pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
            if (pend == LIM) late <= 1'b1;
        end
    end

    assign owed = (pend != '0);

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= LIM); // R7
    AST_TICK_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !take && pend < LIM) |=> pend == $past(pend) + 1'b1); // R7
    AST_TAKE_HAS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend != '0); // R7
    AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        late |=> late); // R8

endmodule

// File: rtl/refsched_fsm.sv
module refsched_fsm
    import refsched_pkg::*;
#(
    parameter int unsigned BURST_N = 4,
    parameter int unsigned TRFC_W  = 6,
    parameter int unsigned BC_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              grouped,
    input  logic [TRFC_W-1:0] trfc,
    input  logic              owed,
    input  logic              gnt,
    output logic              req,
    output logic              busy,
    output logic              take
);
    localparam logic [BC_W-1:0] BURST_LEN = BC_W'(BURST_N);
    localparam logic [BC_W-1:0] ONE_CMD   = BC_W'(1);

    rs_state_e         state, nxt;
    logic [BC_W-1:0]   cmd_left;
    logic [TRFC_W-1:0] gap;
    logic              first_q;

    always_comb begin
        nxt = state;
        unique case (state)
            S_WAIT_INIT: if (init_done) nxt = S_IDLE;
            S_IDLE:      if (owed) nxt = S_REQ;
            S_REQ:       if (gnt) nxt = (cmd_left == ONE_CMD) ? S_IDLE : S_GAP;
            S_GAP:       if (gap <= TRFC_W'(1)) nxt = S_REQ;
            default:     nxt = S_WAIT_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_WAIT_INIT;
            cmd_left <= '0;
            gap      <= '0;
            first_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && owed) begin
                cmd_left <= grouped ? BURST_LEN : ONE_CMD;
                first_q  <= 1'b1;
            end else if (state == S_REQ && gnt) begin
                cmd_left <= cmd_left - 1'b1;
                first_q  <= 1'b0;
                gap      <= trfc;
            end else if (state == S_GAP && gap > TRFC_W'(1)) begin
                gap <= gap - 1'b1;
            end
        end
    end

    always_comb begin
        req  = 1'b0;
        busy = 1'b0;
        unique case (state)
            S_REQ:   begin req = 1'b1; busy = 1'b1; end
            S_GAP:   busy = 1'b1;
            default: ;
        endcase
        take = req && gnt && first_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> req); // R6
    AST_QUIET_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_INIT && !init_done) |=> !req && !busy); // R1
    AST_GAP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gnt && cmd_left != ONE_CMD) |=> !req && busy); // R4

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned WINDOW_US  = 64000,
    parameter int unsigned ROWS       = 4096,
    parameter int unsigned BURST_N    = 8,
    parameter int unsigned PEND_LIMIT = 4,
    parameter int unsigned TRFC_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              grouped_mode,
    input  logic [TRFC_W-1:0] trfc_clks,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ref_busy,
    output logic              ref_late
);
    localparam int unsigned ROW_IVL = (CLK_MHZ * WINDOW_US) / ROWS;
    localparam int unsigned GRP_IVL = (CLK_MHZ * WINDOW_US * BURST_N) / ROWS;
    localparam int unsigned CNT_W   = $clog2(GRP_IVL + 1);
    localparam int unsigned PEND_W  = $clog2(PEND_LIMIT + 1);
    localparam int unsigned BC_W    = $clog2(BURST_N + 1);

    logic tick, owed, take;

    refsched_timer #(
        .ROW_IVL (ROW_IVL),
        .GRP_IVL (GRP_IVL),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (init_done),
        .grouped (grouped_mode),
        .tick    (tick)
    );

    refsched_pending #(
        .LIMIT  (PEND_LIMIT),
        .PEND_W (PEND_W)
    ) u_pending (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .take  (take),
        .owed  (owed),
        .late  (ref_late)
    );

    refsched_fsm #(
        .BURST_N (BURST_N),
        .TRFC_W  (TRFC_W),
        .BC_W    (BC_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .grouped   (grouped_mode),
        .trfc      (trfc_clks),
        .owed      (owed),
        .gnt       (ref_gnt),
        .req       (ref_req),
        .busy      (ref_busy),
        .take      (take)
    );

    AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> ref_busy); // R5

endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int RI = 8;   // floor(1*70/8)
    localparam int GI = 35;  // floor(1*70*4/8)

    typedef struct packed {
        logic       mode;
        logic [5:0] trfc;
        logic [7:0] first;
        logic [3:0] cmds;
        logic [3:0] gap;
        logic [7:0] period;
    } vec_t;

    localparam vec_t [0:3] VECS = '{
        '{1'b0, 6'd3, 8'd10, 4'd1, 4'd0, 8'd8},
        '{1'b1, 6'd3, 8'd37, 4'd4, 4'd3, 8'd35},
        '{1'b1, 6'd0, 8'd37, 4'd4, 4'd1, 8'd35},
        '{1'b1, 6'd5, 8'd37, 4'd4, 4'd5, 8'd35}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_done = 1'b0;
    logic       grouped_mode = 1'b0;
    logic [5:0] trfc_clks = '0;
    logic       ref_gnt = 1'b0;
    logic       ref_req, ref_busy, ref_late;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    refresh_sched #(
        .CLK_MHZ(1), .WINDOW_US(70), .ROWS(8), .BURST_N(4),
        .PEND_LIMIT(3), .TRFC_W(6)
    ) u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .grouped_mode(grouped_mode), .trfc_clks(trfc_clks),
        .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_busy(ref_busy),
        .ref_late(ref_late)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; init_done = 1'b0; ref_gnt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t0, t1, lows, cmds, k, grants;
        vec_t v;

        // R1: reset state and quiet before init
        do_reset();
        check("R1 req after reset", ref_req, 0);
        check("R1 busy after reset", ref_busy, 0);
        check("R1 late after reset", ref_late, 0);
        k = 0;
        repeat (60) begin
            @(negedge clk);
            if (ref_req || ref_busy) k++;
        end
        check("R1 activity without init_done", k, 0);

        // Vector table: R2 R3 R4 R5
        for (int i = 0; i < 4; i++) begin
            v = VECS[i];
            do_reset();
            grouped_mode = v.mode;
            trfc_clks = v.trfc;
            init_done = 1'b1;
            t0 = cyc;
            while (!ref_req && cyc - t0 < 200) @(negedge clk);
            check(v.mode ? "R3 first request latency" : "R2 first request latency",
                  cyc - t0, int'(v.first));
            t1 = cyc;
            cmds = 0;
            lows = 0;
            k = 0;
            while (k < 200) begin
                k++;
                if (ref_req) begin
                    if (cmds > 0) check("R4 recovery gap", lows, int'(v.gap));
                    check("R5 busy with request", ref_busy, 1);
                    ref_gnt = 1'b1;
                    @(negedge clk);
                    ref_gnt = 1'b0;
                    cmds++;
                    lows = 0;
                end else if (!ref_busy) begin
                    break;
                end else begin
                    lows++;
                    @(negedge clk);
                end
            end
            check("R4 commands per event", cmds, int'(v.cmds));
            check("R5 busy dropped after event", ref_busy, 0);
            while (!ref_req && cyc - t1 < 200) @(negedge clk);
            check(v.mode ? "R3 event period" : "R2 request period",
                  cyc - t1, int'(v.period));
        end

        // R7: withheld grants are remembered and served back to back
        do_reset();
        grouped_mode = 1'b0;
        trfc_clks = 6'd2;
        init_done = 1'b1;
        t0 = cyc;
        while (cyc - t0 < 2 * RI + 1) begin
            @(negedge clk);
            if (cyc - t0 > RI + 1) check("R6 request held without grant", ref_req, 1);
        end
        grants = 0;
        repeat (5) begin
            ref_gnt = ref_req;
            if (ref_req) grants++;
            @(negedge clk);
        end
        ref_gnt = 1'b0;
        check("R7 owed events served", grants, 2);
        check("R7 nothing further owed", ref_req, 0);
        check("R8 late below limit", ref_late, 0);

        // R8: late flag at limit, sticky
        do_reset();
        grouped_mode = 1'b0;
        init_done = 1'b1;
        t0 = cyc;
        while (cyc - t0 < 3 * RI) @(negedge clk);
        check("R8 late before limit", ref_late, 0);
        @(negedge clk);
        check("R8 late one clock after reaching limit (early)", ref_late, 0);
        @(negedge clk);
        check("R8 late set", ref_late, 1);
        repeat (6) begin
            ref_gnt = ref_req;
            @(negedge clk);
        end
        ref_gnt = 1'b0;
        check("R8 late sticky after service", ref_late, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule